// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block sits beside one channel of a descriptor-driven DMA engine and decides when that channel interrupts the processor. Each completed packet is counted down from a programmable threshold. When the count runs out, an on-completion interrupt is raised and the count starts over. A restartable idle-delay timer also runs. Every completion with a nonzero delay setting restarts it, and if it runs out before the next completion it raises a delay interrupt. This lets software take one interrupt per burst of packets and still learn about a trailing packet that never filled the threshold.

The engine supplies a one-cycle completion pulse. The register decoder supplies the threshold, delay and interrupt-enable fields of the control register, a strobe for any control write, and a strobe with the two clear bits of a status write. A tick-enable pulse sets the timer rate. The block returns the interrupt line, the two pending bits, the live counter and timer, and the upper part of the status readback word.

Top module: `icoal_top`

## Requirements
- R1: After reset the counter is 1, the timer is 0, both pending bits are 0, the interrupt is low and the status view reads 0x0001_0000.
- R2: A completion that does not bring the counter to zero decrements it by one.
- R3: A completion taken with the counter at 1 sets on-completion pending (pending[0], status bit 12) and reloads the counter from the threshold field.
- R4: A completion taken with the counter at 0 wraps it to all ones (255) and sets no pending bit.
- R5: A completion with a nonzero delay field loads the timer with that value, whatever the timer held. With a zero delay field, the timer keeps counting as if no completion had occurred.
- R6: The timer decrements once per tick-enable while nonzero and holds at 0. The tick that takes it from 1 to 0 sets delay pending (pending[1], status bit 13) and reloads the counter from the threshold.
- R7: When a completion and a timer expiry fall in the same cycle, the counter and the timer follow the completion, and delay pending is still set.
- R8: The interrupt is high exactly when a pending bit and its enable (ctrl_ien bit 0 for on-completion, bit 1 for delay) are both one.
- R9: A status write clears each pending bit whose clear bit is one and leaves the others alone. A set and a clear of the same bit in one cycle leave it set.
- R10: A control write reloads the counter from the threshold field, and this reload takes precedence over a completion in the same cycle.
- R11: The status view carries the timer in bits 31:24, the counter in bits 23:16, on-completion pending in bit 12 and delay pending in bit 13, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_pulse | input | 1 | One packet completed (one cycle) |
| tick_en | input | 1 | Timer advance enable |
| ctrl_thr | input | 8 | Completion threshold field of control |
| ctrl_dly | input | 8 | Delay count field of control |
| ctrl_ien | input | 2 | Interrupt enables: [0] on-completion, [1] delay |
| ctrl_wr | input | 1 | Any control register write happened |
| stat_wr | input | 1 | Status register write happened |
| stat_clr | input | 2 | Write-one-to-clear bits: [0] bit 12, [1] bit 13 |
| irq | output | 1 | Interrupt request |
| pend | output | 2 | Pending bits: [0] on-completion, [1] delay |
| cnt_live | output | 8 | Live completion counter |
| tmr_live | output | 8 | Live delay timer count |
| stat_view | output | 32 | Status readback word for the upper fields |

## Verification
A wrong counter value shows up in stat_view bits 23:16 on the cycle after the completion that caused it. It then shows again as an on-completion interrupt that arrives one completion early or late. A wrong timer shows up in bits 31:24 on the next cycle, and as a delay interrupt raised on the wrong tick or missed entirely. Pending-bit errors reach irq in the cycle right after the event or the status write, so the stimulus checks every output one cycle after each input. It aims at the collisions: completion against expiry, set against clear, and control write against completion.

// File: rtl/icoal_pkg.sv
`timescale 1ns/1ps
package icoal_pkg;
   localparam int REG_W    = 32;
   localparam int THR_LSB  = 16;
   localparam int DLY_LSB  = 24;
   localparam int IOC_BIT  = 12;
   localparam int DLY_BIT  = 13;
   localparam int N_SRC    = 2;

   typedef enum logic [0:0] {
      SRC_IOC = 1'b0,
      SRC_DLY = 1'b1
   } src_e;
endpackage

// File: rtl/icoal_cnt.sv
`timescale 1ns/1ps
module icoal_cnt #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = W'(1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmpl,
   input  logic         reload,
   input  logic         expire,
   input  logic [W-1:0] thr,
   output logic [W-1:0] cnt,
   output logic         hit
);
   localparam logic [W-1:0] ONE = W'(1);

   // a completion at one reaches zero: interrupt and reload
   assign hit = cmpl && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= RST_VAL;
      end else if (reload) begin
         cnt <= thr;
      end else if (cmpl) begin
         cnt <= hit ? thr : (cnt - ONE);
      end else if (expire) begin
         cnt <= thr;
      end
   end
endmodule

// File: rtl/icoal_dly.sv
`timescale 1ns/1ps
module icoal_dly #(
   parameter int W      = 8,
   parameter bit DLY_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmpl,
   input  logic         tick,
   input  logic [W-1:0] dly,
   output logic [W-1:0] tmr,
   output logic         expire
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ZERO = '0;

   generate
      if (DLY_EN) begin : g_timer
         logic restart;
         assign restart = cmpl && (dly != ZERO);
         assign expire  = tick && (tmr == ONE);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tmr <= ZERO;
            end else if (restart) begin
               tmr <= dly;
            end else if (tick && (tmr != ZERO)) begin
               tmr <= tmr - ONE;
            end
         end
      end else begin : g_no_timer
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, cmpl, tick, dly};
         assign tmr    = ZERO;
         assign expire = unused_ok;
      end
   endgenerate
endmodule

// File: rtl/icoal_pend.sv
`timescale 1ns/1ps
module icoal_pend #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_wr,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] pend,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend[i] <= 1'b0;
            end else if (set[i]) begin
               pend[i] <= 1'b1;
            end else if (clr_wr && clr[i]) begin
               pend[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign irq = |(pend & en);
endmodule

// File: rtl/icoal_top.sv
`timescale 1ns/1ps
module icoal_top #(
   parameter int CNT_W  = 8,
   parameter int TMR_W  = 8,
   parameter bit DLY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmpl_pulse,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] ctrl_thr,
   input  logic [TMR_W-1:0] ctrl_dly,
   input  logic [1:0]       ctrl_ien,
   input  logic             ctrl_wr,
   input  logic             stat_wr,
   input  logic [1:0]       stat_clr,
   output logic             irq,
   output logic [1:0]       pend,
   output logic [CNT_W-1:0] cnt_live,
   output logic [TMR_W-1:0] tmr_live,
   output logic [31:0]      stat_view
);
   import icoal_pkg::*;

   localparam int NS = N_SRC;

   generate
      if (CNT_W < 1 || THR_LSB + CNT_W > DLY_LSB) begin : g_bad_cnt
         $error("icoal_top: CNT_W does not fit its status field");
      end
      if (TMR_W < 1 || DLY_LSB + TMR_W > REG_W) begin : g_bad_tmr
         $error("icoal_top: TMR_W does not fit its status field");
      end
      if (NS != 2) begin : g_bad_src
         $error("icoal_top: two interrupt sources expected");
      end
   endgenerate

   logic          hit;
   logic          expire;
   logic [NS-1:0] set_v;

   icoal_dly #(.W(TMR_W), .DLY_EN(DLY_EN)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmpl   (cmpl_pulse),
      .tick   (tick_en),
      .dly    (ctrl_dly),
      .tmr    (tmr_live),
      .expire (expire)
   );

   icoal_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmpl   (cmpl_pulse),
      .reload (ctrl_wr),
      .expire (expire),
      .thr    (ctrl_thr),
      .cnt    (cnt_live),
      .hit    (hit)
   );

   always_comb begin
      set_v          = '0;
      set_v[SRC_IOC] = hit;
      set_v[SRC_DLY] = expire;
   end

   icoal_pend #(.N(NS)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (set_v),
      .clr_wr (stat_wr),
      .clr    (stat_clr),
      .en     (ctrl_ien),
      .pend   (pend),
      .irq    (irq)
   );

   always_comb begin
      stat_view                       = '0;
      stat_view[DLY_LSB +: TMR_W]     = tmr_live;
      stat_view[THR_LSB +: CNT_W]     = cnt_live;
      stat_view[IOC_BIT]              = pend[SRC_IOC];
      stat_view[DLY_BIT]              = pend[SRC_DLY];
   end
endmodule

// File: rtl/icoal_chk.sv
`timescale 1ns/1ps
module icoal_chk #(
   parameter int CNT_W  = 8,
   parameter int TMR_W  = 8,
   parameter bit DLY_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmpl_pulse,
   input logic             tick_en,
   input logic [CNT_W-1:0] ctrl_thr,
   input logic [TMR_W-1:0] ctrl_dly,
   input logic             ctrl_wr,
   input logic             stat_wr,
   input logic [1:0]       stat_clr,
   input logic [1:0]       pend,
   input logic [CNT_W-1:0] cnt_live,
   input logic [TMR_W-1:0] tmr_live
);
   // R2, R3: a completion at one raises on-completion pending and reloads
   assert_ioc_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_pulse && !ctrl_wr && cnt_live == CNT_W'(1))
      |=> (pend[0] && cnt_live == $past(ctrl_thr)));

   // R10: control write reload wins
   assert_ctrl_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (cnt_live == $past(ctrl_thr)));

   // R5: restart of the timer
   assert_tmr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (DLY_EN && cmpl_pulse && ctrl_dly != '0) |=> (tmr_live == $past(ctrl_dly)));

   // R6: expiry raises delay pending
   assert_expiry_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && tmr_live == TMR_W'(1)) |=> pend[1]);

   // R6: an idle timer stays at zero without a restart
   assert_tmr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_live == '0 && !cmpl_pulse) |=> (tmr_live == '0));

   // R9: pending bits are sticky unless cleared
   assert_ioc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && !(stat_wr && stat_clr[0])) |=> pend[0]);
   assert_dly_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[1] && !(stat_wr && stat_clr[1])) |=> pend[1]);
endmodule

bind icoal_top icoal_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W), .DLY_EN(DLY_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmpl_pulse (cmpl_pulse),
   .tick_en    (tick_en),
   .ctrl_thr   (ctrl_thr),
   .ctrl_dly   (ctrl_dly),
   .ctrl_wr    (ctrl_wr),
   .stat_wr    (stat_wr),
   .stat_clr   (stat_clr),
   .pend       (pend),
   .cnt_live   (cnt_live),
   .tmr_live   (tmr_live)
);

// File: tb/icoal_top_tb.sv
`timescale 1ns/1ps
module icoal_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmpl_pulse, tick_en, ctrl_wr, stat_wr;
   logic [7:0]  ctrl_thr, ctrl_dly;
   logic [1:0]  ctrl_ien, stat_clr;
   logic        irq;
   logic [1:0]  pend;
   logic [7:0]  cnt_live, tmr_live;
   logic [31:0] stat_view;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   icoal_top u_dut (
      .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .tick_en(tick_en),
      .ctrl_thr(ctrl_thr), .ctrl_dly(ctrl_dly), .ctrl_ien(ctrl_ien),
      .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .stat_clr(stat_clr),
      .irq(irq), .pend(pend), .cnt_live(cnt_live), .tmr_live(tmr_live),
      .stat_view(stat_view)
   );

   typedef struct packed {
      logic       c, t, cw, sw, w12, w13;
      logic [7:0] thr, dly;
      logic [1:0] en;
      logic [7:0] ecnt, etmr;
      logic [1:0] epend;
      logic       eirq;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 28;
   // fields: cmpl tick cwr swr clr12 clr13 thr dly en | cnt tmr pend irq req
   localparam vec_t VEC [NV] = '{
      '{0,0,1,0,0,0, 3,4,3,  3,0,0,0, 10}, // R10 control write reload
      '{1,0,0,0,0,0, 3,4,3,  2,4,0,0,  2}, // R2 decrement, R5 load
      '{0,1,0,0,0,0, 3,4,3,  2,3,0,0,  6}, // R6 tick
      '{1,0,0,0,0,0, 3,4,3,  1,4,0,0,  5}, // R5 restart
      '{1,1,0,0,0,0, 3,4,3,  3,4,1,1,  3}, // R3 hit and reload
      '{1,0,0,0,0,0, 3,4,3,  2,4,1,1,  2},
      '{0,1,0,0,0,0, 3,4,3,  2,3,1,1,  6},
      '{0,1,0,0,0,0, 3,4,3,  2,2,1,1,  6},
      '{0,1,0,0,0,0, 3,4,3,  2,1,1,1,  6},
      '{0,1,0,0,0,0, 3,4,3,  3,0,3,1,  6}, // R6 expiry sets delay, reloads
      '{0,1,0,0,0,0, 3,4,3,  3,0,3,1,  6}, // R6 holds at zero
      '{0,0,0,1,1,0, 3,4,3,  3,0,2,1,  9}, // R9 clear bit 12 only
      '{0,0,0,0,0,0, 3,4,1,  3,0,2,0,  8}, // R8 delay masked
      '{0,0,0,1,0,1, 3,4,3,  3,0,0,0,  9}, // R9 clear bit 13
      '{1,0,0,0,0,0, 3,4,3,  2,4,0,0,  2},
      '{0,1,0,0,0,0, 3,4,3,  2,3,0,0,  6},
      '{0,1,0,0,0,0, 3,4,3,  2,2,0,0,  6},
      '{0,1,0,0,0,0, 3,4,3,  2,1,0,0,  6},
      '{1,1,0,0,0,0, 3,4,3,  1,4,2,1,  7}, // R7 completion with expiry
      '{1,0,0,1,0,1, 3,4,3,  3,4,1,1,  9}, // R9 clear 13 while 12 sets
      '{1,0,0,0,0,0, 3,4,3,  2,4,1,1,  2},
      '{1,0,0,0,0,0, 3,4,3,  1,4,1,1,  2},
      '{1,0,0,1,1,0, 3,4,3,  3,4,1,1,  9}, // R9 set beats clear
      '{1,1,0,0,0,0, 3,0,3,  2,3,1,1,  5}, // R5 zero delay keeps running
      '{0,0,1,0,0,0, 0,0,3,  0,3,1,1, 10}, // R10 threshold zero
      '{1,0,0,0,0,0, 0,0,3,255,3,1,1,  4}, // R4 wrap, no pending
      '{1,0,1,0,0,0, 5,0,3,  5,3,1,1, 10}, // R10 beats completion
      '{0,0,0,0,0,0, 5,0,0,  5,3,1,0,  8}  // R8 all masked
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_reset_state();
      chk("R1 cnt",  {24'd0, cnt_live}, 32'd1);
      chk("R1 tmr",  {24'd0, tmr_live}, 32'd0);
      chk("R1 pend", {30'd0, pend},     32'd0);
      chk("R1 irq",  {31'd0, irq},      32'd0);
      chk("R1 view", stat_view,         32'h0001_0000);
   endtask

   initial begin
      rst_n = 1'b0; cmpl_pulse = 0; tick_en = 0; ctrl_wr = 0; stat_wr = 0;
      ctrl_thr = 0; ctrl_dly = 0; ctrl_ien = 0; stat_clr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         cmpl_pulse = VEC[i].c;
         tick_en    = VEC[i].t;
         ctrl_wr    = VEC[i].cw;
         stat_wr    = VEC[i].sw;
         stat_clr   = {VEC[i].w13, VEC[i].w12};
         ctrl_thr   = VEC[i].thr;
         ctrl_dly   = VEC[i].dly;
         ctrl_ien   = VEC[i].en;
         @(posedge clk);
         @(negedge clk);
         begin
            string tag;
            tag = $sformatf("R%0d row %0d", VEC[i].req, i);
            chk({tag, " cnt"},  {24'd0, cnt_live}, {24'd0, VEC[i].ecnt});
            chk({tag, " tmr"},  {24'd0, tmr_live}, {24'd0, VEC[i].etmr});
            chk({tag, " pend"}, {30'd0, pend},     {30'd0, VEC[i].epend});
            chk({tag, " irq"},  {31'd0, irq},      {31'd0, VEC[i].eirq});
            // R11 status view layout
            chk({tag, " R11 view"}, stat_view,
                {VEC[i].etmr, VEC[i].ecnt, 2'b00, VEC[i].epend[1], VEC[i].epend[0], 12'h000});
         end
      end
      cmpl_pulse = 0; tick_en = 0; ctrl_wr = 0; stat_wr = 0; stat_clr = 0;
      // R1 reset in the middle of activity
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule